// File: doc/BRIEF.md
# Serial Link Loopback and Receive-Gating Front End

This block sits between the protocol core of a single-wire serial vehicle-bus controller and the external analog transceiver. It holds an 8-bit control register, written by the host over a simple write strobe and always visible on a readback bus. It steers the digital transmit and receive paths according to a separate loopback-mode input.

The block can gate the core's receive path off until the next start-of-frame. It also keeps the core off the bus after an analog-loopback session ends, until the symbol decoder reports an idle bus. All outputs are registered. A cycle's inputs appear on the routing outputs after the next rising clock edge. Blocked paths drive a passive level, set by the parameter `PASSIVE`, whose default is 0.

Top module: `slink_front`

## Requirements
- R1: While `rst` is high at a clock edge, `reg_rdata` becomes 0xE0, `lock_busy` becomes 0, and both `core_rx_out` and `xcvr_tx_out` become the passive level. The rate field is unlocked again.
- R2: A write (`reg_wr`=1) loads bit 7 (ignore-receive), bit 6 (clock select), bit 1 (interrupt enable) and bit 0 (wait control) from `reg_wdata` at the next edge. Bits 3:2 always read 0.
- R3: The rate field, bits 5:4, takes the written value only on the first write after reset. Every later write leaves it unchanged.
- R4: When bit 7 is 1 and `sof_strobe` is 1, bit 7 reads 0 after the edge. If a write occurs in the same cycle, the written bit 7 wins.
- R5: While bit 7 is 1 after an edge, `core_rx_out` is the passive level.
- R6: With `loop_mode` 2'b00 or 2'b11 (normal) and nothing blocking, `core_rx_out` equals the previous cycle's `xcvr_rx_in`, and `xcvr_tx_out` equals the previous cycle's `core_tx_in`.
- R7: With `loop_mode` 2'b01 (digital loopback) and nothing blocking, `core_rx_out` equals the previous cycle's `core_tx_in`, and `xcvr_tx_out` still equals the previous cycle's `core_tx_in`.
- R8: With `loop_mode` 2'b10 (analog loopback), the routing is identical to normal mode.
- R9: In the cycle after `loop_mode` leaves 2'b10, `lock_busy` goes to 1. While it is 1, both `xcvr_tx_out` and `core_rx_out` are the passive level.
- R10: `lock_busy` clears after the first cycle with `idle_strobe`=1 that follows the exit cycle. An idle strobe in the exit cycle itself does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| loop_mode | input | 2 | 00 normal, 01 digital loopback, 10 analog loopback, 11 normal |
| sof_strobe | input | 1 | Start-of-frame seen by symbol decoder |
| idle_strobe | input | 1 | Idle bus seen by symbol decoder |
| core_tx_in | input | 1 | Transmit bit from the protocol core |
| xcvr_rx_in | input | 1 | Receive bit from the analog transceiver |
| core_rx_out | output | 1 | Receive bit delivered to the protocol core |
| xcvr_tx_out | output | 1 | Transmit bit driven to the analog transceiver |
| lock_busy | output | 1 | Post-analog-loopback lockout active |

## Verification
The assertions assume that `loop_mode` is a settled synchronous input, so each cycle's value is a real mode. They also assume that the decoder strobes are single-cycle pulses aligned to the clock, and that they may coincide with each other and with register writes. The stimulus changes every input only at the falling clock edge. It holds `loop_mode` for many cycles at a time and switches it rarely, so that lockout entry and exit both occur. It forces the hard coincidences: an idle strobe in the exit cycle, a start-of-frame in the same cycle as a write, and repeated writes after the rate field has locked.

// File: rtl/slink_pkg.sv
package slink_pkg;
  typedef enum logic [1:0] {
    LM_NORMAL  = 2'b00,
    LM_DIGITAL = 2'b01,
    LM_ANALOG  = 2'b10,
    LM_ALT     = 2'b11
  } loop_mode_e;

  typedef struct packed {
    logic       ign;
    logic       clk_sel;
    logic [1:0] rate;
    logic [1:0] rsvd;
    logic       irq_en;
    logic       wait_ctl;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'hE0;
endpackage

// File: rtl/slink_ctrl_reg.sv
module slink_ctrl_reg
  import slink_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         sof,
  output ctrl_t        ctrl_q,
  output logic         ign_nxt
);
  ctrl_t ctrl_d;
  logic  rate_locked_q;
  logic  unused_rsvd;

  assign unused_rsvd = ^wr_data[3:2];

  always_comb begin
    ctrl_d = ctrl_q;
    if (sof && ctrl_q.ign) ctrl_d.ign = 1'b0;
    if (wr_en) begin
      ctrl_d.ign      = wr_data[7];
      ctrl_d.clk_sel  = wr_data[6];
      ctrl_d.irq_en   = wr_data[1];
      ctrl_d.wait_ctl = wr_data[0];
      if (!rate_locked_q) ctrl_d.rate = wr_data[5:4];
    end
    ctrl_d.rsvd = 2'b00;
  end

  assign ign_nxt = ctrl_d.ign;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q        <= ctrl_t'(CTRL_RESET);
      rate_locked_q <= 1'b0;
    end else begin
      ctrl_q        <= ctrl_d;
      rate_locked_q <= rate_locked_q | wr_en;
    end
  end

  // R2: reserved field never reads back nonzero
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.rsvd == 2'b00);
  // R3: once locked, rate never moves
  a_r3_rate_frozen: assert property (@(posedge clk) disable iff (rst)
    rate_locked_q |=> $stable(ctrl_q.rate));
  // R4: start-of-frame without a write clears the ignore bit
  a_r4_sof_clears: assert property (@(posedge clk) disable iff (rst)
    (sof && ctrl_q.ign && !wr_en) |=> !ctrl_q.ign);
  // R2: written ignore bit lands
  a_r2_ign_written: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl_q.ign == $past(wr_data[7])));
endmodule

// File: rtl/slink_lockout.sv
module slink_lockout
  import slink_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  loop_mode_e mode,
  input  logic       idle,
  output logic       lock_nxt,
  output logic       lock_q
);
  logic was_analog_q;
  logic exit_now;

  assign exit_now = was_analog_q && (mode != LM_ANALOG);

  always_comb begin
    lock_nxt = lock_q;
    if (exit_now)         lock_nxt = 1'b1;
    else if (lock_q && idle) lock_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      was_analog_q <= 1'b0;
      lock_q       <= 1'b0;
    end else begin
      was_analog_q <= (mode == LM_ANALOG);
      lock_q       <= lock_nxt;
    end
  end

  // R9: leaving analog loopback arms the lockout
  a_r9_exit_arms: assert property (@(posedge clk) disable iff (rst)
    (was_analog_q && mode != LM_ANALOG) |=> lock_q);
  // R10: idle strobe after the exit cycle releases it
  a_r10_idle_releases: assert property (@(posedge clk) disable iff (rst)
    (lock_q && idle && !(was_analog_q && mode != LM_ANALOG)) |=> !lock_q);
  // R10: lockout only rises on an exit
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && !(was_analog_q && mode != LM_ANALOG)) |=> !lock_q);
endmodule

// File: rtl/slink_route.sv
module slink_route
  import slink_pkg::*;
#(
  parameter logic PASSIVE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  loop_mode_e mode,
  input  logic       core_tx,
  input  logic       xcvr_rx,
  input  logic       rx_block,
  input  logic       tx_block,
  output logic       core_rx_q,
  output logic       xcvr_tx_q
);
  logic rx_src;

  always_comb begin
    unique case (mode)
      LM_DIGITAL: rx_src = core_tx;
      default:    rx_src = xcvr_rx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rx_q <= PASSIVE;
      xcvr_tx_q <= PASSIVE;
    end else begin
      core_rx_q <= (rx_block || tx_block) ? PASSIVE : rx_src;
      xcvr_tx_q <= tx_block ? PASSIVE : core_tx;
    end
  end

  // R9: lockout forces the transmit pin passive
  a_r9_tx_passive: assert property (@(posedge clk) disable iff (rst)
    tx_block |=> (xcvr_tx_q == PASSIVE));
  // R5: gated receiver delivers passive
  a_r5_rx_passive: assert property (@(posedge clk) disable iff (rst)
    rx_block |=> (core_rx_q == PASSIVE));
  // R7: digital loopback feeds transmit into receive and still drives the pin
  a_r7_loop_path: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_DIGITAL && !rx_block && !tx_block) |=>
      (core_rx_q == $past(core_tx) && xcvr_tx_q == $past(core_tx)));
endmodule

// File: rtl/slink_front.sv
module slink_front
  import slink_pkg::*;
#(
  parameter logic PASSIVE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] loop_mode,
  input  logic       sof_strobe,
  input  logic       idle_strobe,
  input  logic       core_tx_in,
  input  logic       xcvr_rx_in,
  output logic       core_rx_out,
  output logic       xcvr_tx_out,
  output logic       lock_busy
);
  ctrl_t      ctrl_q;
  logic       ign_nxt;
  logic       lock_nxt;
  loop_mode_e mode;

  assign mode = loop_mode_e'(loop_mode);

  slink_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .sof     (sof_strobe),
    .ctrl_q  (ctrl_q),
    .ign_nxt (ign_nxt)
  );

  slink_lockout u_lock (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .idle     (idle_strobe),
    .lock_nxt (lock_nxt),
    .lock_q   (lock_busy)
  );

  slink_route #(.PASSIVE(PASSIVE)) u_route (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .core_tx   (core_tx_in),
    .xcvr_rx   (xcvr_rx_in),
    .rx_block  (ign_nxt),
    .tx_block  (lock_nxt),
    .core_rx_q (core_rx_out),
    .xcvr_tx_q (xcvr_tx_out)
  );

  assign reg_rdata = ctrl_q;

  // R1: register, lockout and pins leave reset in their defined state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (reg_rdata == 8'hE0 && !lock_busy &&
             core_rx_out == PASSIVE && xcvr_tx_out == PASSIVE));
endmodule

// File: tb/slink_front_bench.sv
module slink_front_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [1:0] loop_mode;
  logic       sof_strobe, idle_strobe, core_tx_in, xcvr_rx_in;
  logic       core_rx_out, xcvr_tx_out, lock_busy;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_ctrl;
  logic       m_wlock, m_was_an, m_lock, m_rx, m_tx;
  logic       m_prev_lock;

  always #2.5 clk = ~clk;

  slink_front u_slink_front (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .loop_mode(loop_mode), .sof_strobe(sof_strobe),
    .idle_strobe(idle_strobe), .core_tx_in(core_tx_in), .xcvr_rx_in(xcvr_rx_in),
    .core_rx_out(core_rx_out), .xcvr_tx_out(xcvr_tx_out), .lock_busy(lock_busy)
  );

  function automatic logic [7:0] next_ctrl(logic [7:0] c, logic wl, logic wr,
                                           logic [7:0] wd, logic sof);
    logic [7:0] n = c;
    if (sof && n[7]) n[7] = 1'b0;
    if (wr) begin
      n[7] = wd[7]; n[6] = wd[6]; n[1:0] = wd[1:0];
      if (!wl) n[5:4] = wd[5:4];
    end
    n[3:2] = 2'b00;
    return n;
  endfunction

  function automatic logic pick_rx(logic [1:0] md, logic ctx, logic xrx);
    return (md == 2'b01) ? ctx : xrx;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic [7:0] nc;
    logic ex, nl;
    @(posedge clk);
    if (rst) begin
      m_ctrl = 8'hE0; m_wlock = 0; m_was_an = 0; m_lock = 0; m_rx = 0; m_tx = 0;
    end else begin
      nc = next_ctrl(m_ctrl, m_wlock, reg_wr, reg_wdata, sof_strobe);
      m_wlock = m_wlock | reg_wr;
      ex = m_was_an && (loop_mode != 2'b10);
      nl = ex ? 1'b1 : ((m_lock && idle_strobe) ? 1'b0 : m_lock);
      m_was_an = (loop_mode == 2'b10);
      m_rx = (nc[7] || nl) ? 1'b0 : pick_rx(loop_mode, core_tx_in, xcvr_rx_in);
      m_tx = nl ? 1'b0 : core_tx_in;
      m_ctrl = nc; m_lock = nl;
    end
    @(negedge clk);
    chk(reg_rdata == m_ctrl, "R2 R3 R4 register readback", reg_rdata, m_ctrl);
    chk(lock_busy == m_lock, "R9 R10 lockout status", {7'd0, lock_busy}, {7'd0, m_lock});
    chk(core_rx_out == m_rx,
        m_ctrl[7] ? "R5 gated receive" : (loop_mode == 2'b01 ? "R7 loopback receive" :
        (loop_mode == 2'b10 ? "R8 analog receive" : "R6 normal receive")),
        {7'd0, core_rx_out}, {7'd0, m_rx});
    chk(xcvr_tx_out == m_tx, m_lock ? "R9 passive transmit" : "R6 R7 R8 transmit",
        {7'd0, xcvr_tx_out}, {7'd0, m_tx});
  endtask

  task automatic idle_inputs();
    reg_wr = 0; reg_wdata = 0; sof_strobe = 0; idle_strobe = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1850));
    rst = 1; loop_mode = 2'b00; core_tx_in = 0; xcvr_rx_in = 0; idle_inputs();
    @(negedge clk);
    cyc(); cyc();
    // R1: reset state
    chk(reg_rdata == 8'hE0 && !lock_busy && !core_rx_out && !xcvr_tx_out,
        "R1 reset state", reg_rdata, 8'hE0);
    rst = 0;
    // R5: ignore set from reset, receive gated
    xcvr_rx_in = 1; core_tx_in = 1; cyc();
    chk(core_rx_out == 1'b0, "R5 gated after reset", {7'd0, core_rx_out}, 8'd0);
    // R4: SOF and write in same cycle, write of 1 wins
    sof_strobe = 1; reg_wr = 1; reg_wdata = 8'hFF; cyc();
    chk(reg_rdata == 8'hF3, "R2 R3 first write", reg_rdata, 8'hF3);
    // R3: later write ignored in rate field
    reg_wr = 1; reg_wdata = 8'h80; sof_strobe = 0; cyc();
    chk(reg_rdata[5:4] == 2'b11, "R3 rate frozen", {6'd0, reg_rdata[5:4]}, 8'd3);
    // R4: SOF clears ignore
    reg_wr = 0; sof_strobe = 1; cyc();
    chk(reg_rdata[7] == 1'b0, "R4 sof clears ignore", {7'd0, reg_rdata[7]}, 8'd0);
    sof_strobe = 0; cyc();
    chk(core_rx_out == 1'b1, "R6 normal receive passes", {7'd0, core_rx_out}, 8'd1);
    // R7: digital loopback
    loop_mode = 2'b01; xcvr_rx_in = 0; core_tx_in = 1; cyc();
    chk(core_rx_out == 1'b1 && xcvr_tx_out == 1'b1, "R7 loopback path",
        {6'd0, core_rx_out, xcvr_tx_out}, 8'd3);
    // R8 then R9/R10: exit analog with idle in exit cycle
    loop_mode = 2'b10; cyc(); cyc();
    loop_mode = 2'b00; idle_strobe = 1; cyc();
    chk(lock_busy == 1'b1 && xcvr_tx_out == 1'b0, "R9 R10 lock holds",
        {6'd0, lock_busy, xcvr_tx_out}, 8'd2);
    idle_strobe = 0; cyc(); cyc();
    idle_strobe = 1; cyc();
    chk(lock_busy == 1'b0, "R10 idle releases", {7'd0, lock_busy}, 8'd0);
    idle_strobe = 0;
    // random phase
    for (int i = 0; i < 6000; i++) begin
      rst         = ($urandom_range(0, 699) == 0);
      reg_wr      = ($urandom_range(0, 7) == 0);
      reg_wdata   = 8'($urandom);
      sof_strobe  = ($urandom_range(0, 5) == 0);
      idle_strobe = ($urandom_range(0, 9) == 0);
      core_tx_in  = 1'($urandom);
      xcvr_rx_in  = 1'($urandom);
      if ($urandom_range(0, 15) == 0) loop_mode = 2'($urandom);
      cyc();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule